// File: doc/BRIEF.md
# Prescaled SPI Master

This block is a register-mapped SPI master that moves one word at a time. Software sets a clock prescale code and a word-length bit, drives a single chip-select through a control bit, and writes the transmit register to launch one full-duplex transfer of 8 or 16 bits. While the word shifts out on MOSI, the same number of bits is captured from MISO. When the last bit is in, the word lands in the receive register and a completion flag is raised. Software clears the flag itself before starting the next word.

The serial clock is the system clock divided by an even ratio from 4 to 30, chosen by a 5-bit code. Chip-select is never touched by transfers, so any number of words can be grouped under one selection. A read-only transfer is a write of any dummy value followed by a read of the receive register once the flag is set.

Register map (3-bit address): 0 = configuration, 1 = control/status, 2 = transmit word, 3 = receive word, 4 = completion flag; other addresses read as zero.

Top module: `spiMaster`

## Requirements
- R1: A write to address 2 while no transfer is running starts one transfer; control bit 1 (busy) reads 1 from the next cycle until the transfer ends, and the transfer lasts (word bits × divide ratio) clock cycles.
- R2: Configuration bit 8 selects the word length: 1 gives 16-bit transfers, 0 gives 8-bit transfers; it is 1 after reset. The length is taken when a transfer starts.
- R3: Configuration bits 4:0 hold the prescale code p; for p from 0x12 to 0x1F the SCK period is 2 × (p − 0x10) clock cycles, high and low halves equal. Codes below 0x12 act as 0x12. The code is 0x12 after reset and is taken when a transfer starts.
- R4: SPI mode 0: SCK idles low, the first data bit is on MOSI from the start cycle, MOSI changes only on falling SCK edges, MISO is sampled on rising edges, most significant bit first. MOSI is low while idle.
- R5: In 16-bit mode the transmit word goes out byte 0 (bits 7:0) first, then byte 1 (bits 15:8); the first received byte lands in receive bits 7:0 and the second in bits 15:8. In 8-bit mode bits 7:0 are sent and the received byte lands in bits 7:0 with bits 15:8 zero.
- R6: Control bit 0 drives the active-low chip-select: csN equals the inverse of that bit, is high after reset, and no transfer changes it.
- R7: Address 4 bit 0 reads 1 from the same cycle the received word is loaded at the end of a transfer; a write to address 4 with bit 0 clear clears it, a write with bit 0 set leaves it unchanged.
- R8: A write to address 2 while busy is ignored: the transmit register readback and the running transfer are unchanged.
- R9: The receive register holds the last completed word and changes only when a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for `addr` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low chip-select |

## Verification
A wrong half-period count or toggle count shows within one SCK half period as an SCK or MOSI edge in the wrong cycle, or as the busy bit dropping early or late, so SCK, MOSI, csN and the addressed register are compared with a reference model in every cycle. A byte-order or sample-edge fault in the receive path only shows once the word completes, at the receive readback and the flag in the cycle after the last falling edge. Odd prescale codes, codes below the legal range, both word lengths and transmit writes during a transfer are applied so that divider and length faults cannot hide behind the default settings.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int REG_AW = 3;
  localparam int WORD   = 16;
  localparam int BYTE   = WORD / 2;

  localparam logic [REG_AW-1:0] ADDR_CFG   = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_TXD   = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_RXD   = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_CAUSE = 3'd4;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic start;   // load a new word
    logic sample;  // rising SCK: capture MISO
    logic shift;   // falling SCK (not last): advance MOSI
    logic finish;  // last falling SCK: publish received word
    logic wide;    // 16-bit word in flight
  } strobe_t;
endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import spi_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [WORD-1:0]   wrData,
  output logic [PRE_W-1:0]  cfgPre,
  output logic              cfgWide,
  output logic              csEnable,
  output logic              busy,
  output logic              causeFlag,
  output logic              sck,
  output strobe_t           strb
);
  localparam int CNT_W  = PRE_W - 1;
  localparam int BASE   = 1 << (PRE_W - 1);
  localparam int MINPRE = BASE + 2;
  localparam int TGL_W  = $clog2(2 * WORD);

  logic [PRE_W-1:0] effPre;
  logic [CNT_W-1:0] halfNext, halfReg, halfCnt;
  logic [TGL_W-1:0] tglCnt, tglLast;
  logic             wideReg, startGo, toggle, lastTgl;

  assign effPre   = (cfgPre < PRE_W'(MINPRE)) ? PRE_W'(MINPRE) : cfgPre;
  assign halfNext = CNT_W'(effPre - PRE_W'(BASE));
  assign startGo  = wrEn && (wrAddr == ADDR_TXD) && !busy;
  assign toggle   = busy && (halfCnt == halfReg - CNT_W'(1));
  assign tglLast  = wideReg ? TGL_W'(2 * WORD - 1) : TGL_W'(2 * BYTE - 1);
  assign lastTgl  = toggle && (tglCnt == tglLast);

  always_comb begin
    strb.start  = startGo;
    strb.sample = toggle && !sck;
    strb.shift  = toggle && sck && !lastTgl;
    strb.finish = lastTgl;
    strb.wide   = startGo ? cfgWide : wideReg;
  end

  // transfer sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      halfCnt <= '0;
      tglCnt  <= '0;
      halfReg <= CNT_W'(2);
      wideReg <= 1'b1;
    end else if (startGo) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      halfCnt <= '0;
      tglCnt  <= '0;
      halfReg <= halfNext;
      wideReg <= cfgWide;
    end else if (busy) begin
      if (toggle) begin
        halfCnt <= '0;
        sck     <= ~sck;
        tglCnt  <= tglCnt + TGL_W'(1);
        if (lastTgl) busy <= 1'b0;
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
    end
  end

  // software-visible settings and completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPre    <= PRE_W'(MINPRE);
      cfgWide   <= 1'b1;
      csEnable  <= 1'b0;
      causeFlag <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CFG) begin
        cfgPre  <= wrData[PRE_W-1:0];
        cfgWide <= wrData[8];
      end
      if (wrEn && wrAddr == ADDR_CTRL) csEnable <= wrData[0];
      if (lastTgl) causeFlag <= 1'b1;
      else if (wrEn && wrAddr == ADDR_CAUSE && !wrData[0]) causeFlag <= 1'b0;
    end
  end

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);
  assert_flag_on_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> causeFlag);
  assert_cs_untouched_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_CTRL) |=> $stable(csEnable));
  assert_half_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfReg >= CNT_W'(2)));
endmodule

// File: rtl/spiData.sv
module spiData
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [WORD-1:0]   wrData,
  input  logic              busy,
  input  strobe_t           strb,
  input  logic              miso,
  output logic [WORD-1:0]   txReg,
  output logic [WORD-1:0]   rxReg,
  output logic              mosi
);
  logic [WORD-1:0] txShift, rxShift, loadWord, rxWord;

  // byte 0 leaves first; in byte mode only byte 0 is sent
  assign loadWord = strb.wide ? {wrData[BYTE-1:0], wrData[WORD-1:BYTE]}
                              : {wrData[BYTE-1:0], {BYTE{1'b0}}};
  // first received byte goes to the low lane
  assign rxWord   = strb.wide ? {rxShift[BYTE-1:0], rxShift[WORD-1:BYTE]}
                              : {{BYTE{1'b0}}, rxShift[BYTE-1:0]};
  assign mosi     = busy & txShift[WORD-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      rxReg   <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_TXD && !busy) txReg <= wrData;
      if (strb.start) txShift <= loadWord;
      else if (strb.shift) txShift <= {txShift[WORD-2:0], 1'b0};
      if (strb.sample) rxShift <= {rxShift[WORD-2:0], miso};
      if (strb.finish) rxReg <= rxWord;
    end
  end

  assert_tx_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(txReg));
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(rxReg));
  assert_mosi_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosi);
endmodule

// File: rtl/spiMaster.sv
module spiMaster
  import spi_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD-1:0]   wrData,
  output logic [WORD-1:0]   rdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  logic [PRE_W-1:0] cfgPre;
  logic             cfgWide, csEnable, busy, causeFlag;
  logic [WORD-1:0]  txReg, rxReg;
  strobe_t          strb;

  spiCtrl #(.PRE_W(PRE_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(addr), .wrData(wrData),
    .cfgPre(cfgPre), .cfgWide(cfgWide), .csEnable(csEnable), .busy(busy),
    .causeFlag(causeFlag), .sck(sck), .strb(strb)
  );

  spiData data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(addr), .wrData(wrData),
    .busy(busy), .strb(strb), .miso(miso), .txReg(txReg), .rxReg(rxReg),
    .mosi(mosi)
  );

  assign csN = ~csEnable;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CFG:   begin rdData[PRE_W-1:0] = cfgPre; rdData[8] = cfgWide; end
      ADDR_CTRL:  rdData[1:0] = {busy, csEnable};
      ADDR_TXD:   rdData = txReg;
      ADDR_RXD:   rdData = rxReg;
      ADDR_CAUSE: rdData[0] = causeFlag;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: tb/spiMaster_test.sv
module spiMaster_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd1;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        sck, mosi, csN;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  spiMaster uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN)
  );

  int vectors = 0;
  int misses  = 0;

  // reference model state
  int          mPre = 18, mH = 2, mBits = 16, mJ = 0;
  bit          mWide = 1, mCs = 0, mBusy = 0, mCause = 0;
  logic [15:0] mTxd = 0, mRxd = 0, mWire = 0, mSlave = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return {7'd0, mWide, 3'd0, 5'(mPre)};
      3'd1: return {14'd0, mBusy, mCs};
      3'd2: return mTxd;
      3'd3: return mRxd;
      3'd4: return {15'd0, mCause};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string readTag(logic [2:0] a);
    case (a)
      3'd0: return "R3 cfg readback";
      3'd1: return "R1 busy/cs readback";
      3'd2: return "R8 tx readback";
      3'd3: return "R9 rx readback";
      default: return "R7 flag readback";
    endcase
  endfunction

  task automatic modelEdge();
    bit wasBusy = mBusy;
    bit ended = 0;
    if (mBusy) begin
      mJ++;
      if (mJ == 2 * mH * mBits) begin
        mBusy = 0; mCause = 1; ended = 1;
        mRxd = (mBits == 16) ? {mSlave[7:0], mSlave[15:8]} : {8'd0, mSlave[7:0]};
      end
    end
    if (wrEn) begin
      case (addr)
        3'd0: begin mPre = int'(wrData[4:0]); mWide = wrData[8]; end
        3'd1: mCs = wrData[0];
        3'd2: if (!wasBusy) begin
          mTxd = wrData; mBusy = 1; mJ = 0;
          mH = ((mPre < 18) ? 18 : mPre) - 16;
          mBits = mWide ? 16 : 8;
          mWire = mWide ? {wrData[7:0], wrData[15:8]} : {wrData[7:0], 8'd0};
        end
        3'd4: if (!wrData[0] && !ended) mCause = 0;
        default: ;
      endcase
    end
  endtask

  function automatic logic slaveBit(int b);
    return (mBits == 16) ? mSlave[15 - b] : mSlave[7 - b];
  endfunction

  task automatic compareAll();
    logic expSck  = mBusy && (((mJ / mH) % 2) == 1);
    logic expMosi = mBusy ? mWire[15 - mJ / (2 * mH)] : 1'b0;
    check("R3 sck timing", {15'd0, sck}, {15'd0, expSck});
    check("R4 mosi data", {15'd0, mosi}, {15'd0, expMosi});
    check("R6 csN level", {15'd0, csN}, {15'd0, !mCs});
    #1;
    check(readTag(addr), rdData, modelRead(addr));
    miso = mBusy ? slaveBit(mJ / (2 * mH)) : 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0; addr = 3'd1;
  endtask

  task automatic look(logic [2:0] a);
    addr = a;
    step();
    addr = 3'd1;
  endtask

  // R1 R2 R5: run a transfer to completion, then check the received word
  task automatic xfer(logic [15:0] tx, logic [15:0] slave);
    mSlave = slave;
    wr(3'd2, tx);
    while (mBusy) step();
    look(3'd3);
    look(3'd4);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: R2 R3 R6 R7
    @(negedge clk);
    check("R6 csN after reset", {15'd0, csN}, 16'd1);
    look(3'd0);
    look(3'd4);
    wr(3'd1, 16'd1);                 // R6 select on
    xfer(16'h1234, 16'hA5C3);        // R5 16-bit, ratio 4
    look(3'd2);
    wr(3'd4, 16'd1);                 // R7 write with bit0 set keeps flag
    look(3'd4);
    wr(3'd4, 16'd0);                 // R7 clear
    look(3'd4);
    // R8: write while busy, slow divider
    wr(3'd0, 16'h011F);
    mSlave = 16'h5E17;
    wr(3'd2, 16'hBEEF);
    repeat (7) step();
    wr(3'd2, 16'hFFFF);
    look(3'd2);
    while (mBusy) step();
    look(3'd2);
    look(3'd3);
    // R2: byte mode, odd code
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h0015);
    xfer(16'hABC7, 16'h003C);
    // R3: code below legal range acts as fastest
    wr(3'd0, 16'h0005);
    xfer(16'h0081, 16'h00E2);
    // R9: dummy read-only transfer, 16-bit, select dropped (R6)
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0113);
    xfer(16'hFFFF, 16'h9C41);
    wr(3'd4, 16'd0);
    repeat (5) look(3'd3);
    // back-to-back start in the completion cycle region
    wr(3'd1, 16'd1);
    mSlave = 16'h0F0F;
    wr(3'd2, 16'h3344);
    while (mBusy) begin
      if (mJ == 2 * mH * mBits - 1) wr(3'd2, 16'h7777); else step();
    end
    look(3'd2);
    look(3'd3);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule